// File: doc/BRIEF.md
# Mailbox Interrupt Register Block

This block holds the pending state of one mailbox interrupt group with 32 sources. It is reached over a plain 32-bit register bus that has an address, a write enable, write data and read data. Software raises a source by writing ones to a set alias and acknowledges a source by writing ones to a clear alias. It can see which sources are pending through a status view and through either alias. An enable register chooses which pending sources drive the single level interrupt line.

Hardware event inputs can also mark sources pending. Because software can raise a source itself, a driver can inject interrupts to stress-test its own handler. The status read that follows a write already shows the new value, so that read can act as a write flush. The interrupt line never reports a pending condition that the status and enable registers do not hold, so a handler that finds nothing pending has seen a genuinely spurious interrupt and not a timing artefact.

Register map (byte addresses, word aligned): set alias at 0x00, clear alias at 0x04, status at 0x08, enable at 0x0C. Bit n of each register belongs to source n.

Top module: `mbx_irq_regs`

## Requirements
- R1: After reset, status, enable and the irq output are all zero.
- R2: A write to the set alias (0x00) makes pending every status bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to the clear alias (0x04) removes every pending status bit whose write-data bit is 1, unless a hardware event sets that bit in the same cycle. Bits written as 0 keep their value.
- R4: A read of the status register (0x08) returns the pending bits, already updated in the cycle after a set or clear write. Writes to 0x08 change nothing.
- R5: The enable register (0x0C) takes the full write data and reads back exactly what was written.
- R6: The irq output is a register. It equals the OR over all bits of status AND enable, and it changes on the same clock edge as the status or enable register it follows. It is never 1 while the masked status is zero.
- R7: A 1 on hw_evt bit n in a cycle makes bit n pending at the next edge. It wins over a clear of the same bit in that cycle.
- R8: Reads of the set alias and of the clear alias return the current status value.
- R9: An address that is not word aligned, or that is at or above 0x10, reads as zero, and writes to it change neither status nor enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (5) | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, valid in the same cycle |
| hw_evt | input | DATA_W (32) | Per-source hardware set pulses |
| irq | output | 1 | Level interrupt, high while any enabled source is pending |

## Verification
The assertions check on every cycle that irq agrees with the masked status, and that each set, clear, enable and hardware event write has landed at the next edge. They also check that enable never moves without a write to it, and that unmapped writes leave both registers untouched. The exact values that the bus reads return, which include the alias readback, the zero from unmapped addresses and the ignored status write, can only be shown by the bench's scenarios. The bench also sweeps every source bit individually and drives a pseudo-random sequence of mixed writes. It sets up a collision where a hardware event and a software clear hit the same bit in the same cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Word offsets (address bits [3:2]) of the four registers
  localparam logic [1:0] IDX_SET  = 2'd0;
  localparam logic [1:0] IDX_CLR  = 2'd1;
  localparam logic [1:0] IDX_STAT = 2'd2;
  localparam logic [1:0] IDX_ENA  = 2'd3;

  typedef enum logic [2:0] {
    SEL_SET,
    SEL_CLR,
    SEL_STAT,
    SEL_ENA,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  output reg_sel_e          sel,
  output logic              wr_set,
  output logic              wr_clr,
  output logic              wr_ena
);
  logic mapped;

  // Only aligned words below 0x10 belong to the block
  assign mapped = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:4] == '0);

  always_comb begin
    sel = SEL_NONE;
    if (mapped) begin
      case (bus_addr[3:2])
        IDX_SET:  sel = SEL_SET;
        IDX_CLR:  sel = SEL_CLR;
        IDX_STAT: sel = SEL_STAT;
        default:  sel = SEL_ENA;
      endcase
    end
  end

  assign wr_set = bus_we && (sel == SEL_SET);
  assign wr_clr = bus_we && (sel == SEL_CLR);
  assign wr_ena = bus_we && (sel == SEL_ENA);
endmodule

// File: rtl/mbx_pending_bank.sv
module mbx_pending_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_evt,
  output logic [DATA_W-1:0] stat_d,
  output logic [DATA_W-1:0] stat_q
);
  // Per source: clear first, then set from software or hardware, so a set wins
  for (genvar g = 0; g < DATA_W; g++) begin : g_src
    assign stat_d[g] = (stat_q[g] & ~(wr_clr & wdata[g]))
                     | (wr_set & wdata[g])
                     | hw_evt[g];
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] stat_d,
  input  logic [DATA_W-1:0] ena_d,
  output logic              irq
);
  // Loaded from next-state values: tracks the registers without lag
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat_d & ena_d);
  end
endmodule

// File: rtl/mbx_irq_regs.sv
module mbx_irq_regs
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] hw_evt,
  output logic              irq
);
  reg_sel_e          sel;
  logic              wr_set, wr_clr, wr_ena;
  logic [DATA_W-1:0] stat_d, stat_q;
  logic [DATA_W-1:0] ena_d, ena_q;

  mbx_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .sel      (sel),
    .wr_set   (wr_set),
    .wr_clr   (wr_clr),
    .wr_ena   (wr_ena)
  );

  mbx_pending_bank #(.DATA_W(DATA_W)) bank_i (
    .clk    (clk),
    .rst    (rst),
    .wr_set (wr_set),
    .wr_clr (wr_clr),
    .wdata  (bus_wdata),
    .hw_evt (hw_evt),
    .stat_d (stat_d),
    .stat_q (stat_q)
  );

  assign ena_d = wr_ena ? bus_wdata : ena_q;

  always_ff @(posedge clk) begin
    if (rst) ena_q <= '0;
    else     ena_q <= ena_d;
  end

  mbx_irq_gen #(.DATA_W(DATA_W)) irq_i (
    .clk    (clk),
    .rst    (rst),
    .stat_d (stat_d),
    .ena_d  (ena_d),
    .irq    (irq)
  );

  always_comb begin
    case (sel)
      SEL_SET, SEL_CLR, SEL_STAT: bus_rdata = stat_q;
      SEL_ENA:                    bus_rdata = ena_q;
      default:                    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbx_irq_regs_chk.sv
module mbx_irq_regs_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] hw_evt,
  input logic              irq,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] ena_q
);
  logic is_set, is_clr, is_ena, unmapped;
  assign unmapped = (bus_addr[1:0] != 2'b00) || (bus_addr[ADDR_W-1:4] != '0);
  assign is_set = !unmapped && (bus_addr[3:2] == 2'd0);
  assign is_clr = !unmapped && (bus_addr[3:2] == 2'd1);
  assign is_ena = !unmapped && (bus_addr[3:2] == 2'd3);

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & ena_q));

  assert_set_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && is_set) |=> ((stat_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clr_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && is_clr) |=> ((stat_q & $past(bus_wdata) & ~$past(hw_evt)) == '0));

  assert_hw_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (hw_evt != '0) |=> ((stat_q & $past(hw_evt)) == $past(hw_evt)));

  assert_ena_write_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && is_ena) |=> (ena_q == $past(bus_wdata)));

  assert_ena_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && is_ena) |=> $stable(ena_q));

  assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_we && unmapped && hw_evt == '0) |=> ($stable(stat_q) && $stable(ena_q)));
endmodule

bind mbx_irq_regs mbx_irq_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .hw_evt    (hw_evt),
  .irq       (irq),
  .stat_q    (stat_q),
  .ena_q     (ena_q)
);

// File: tb/mbx_irq_regs_tb.sv
`timescale 1ns/1ps
module mbx_irq_regs_tb_top;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam logic [AW-1:0] A_SET = 5'h00, A_CLR = 5'h04, A_STAT = 5'h08, A_ENA = 5'h0C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [DW-1:0] hw_evt = '0;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] m_stat = '0;
  logic [DW-1:0] m_ena = '0;
  logic [31:0]   lfsr = 32'hACE1_1234;

  always #5 clk = ~clk;

  mbx_irq_regs #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_evt(hw_evt), .irq(irq)
  );

  task automatic cmp(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == A_SET)      m_stat = m_stat | d;
    else if (a == A_CLR) m_stat = m_stat & ~d;
    else if (a == A_ENA) m_ena = d;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    bus_addr = a;
    #1;
    cmp(bus_rdata, exp, req);
  endtask

  task automatic chk_irq(input string req);
    cmp({31'd0, irq}, {31'd0, |(m_stat & m_ena)}, req);
  endtask

  function automatic logic [31:0] step(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(A_STAT, '0, "R1 status");
    rd(A_ENA, '0, "R1 enable");
    cmp({31'd0, irq}, '0, "R1 irq");

    // per-bit sweep: R2, R3, R5, R6
    for (int i = 0; i < DW; i++) begin
      wr(A_SET, DW'(1) << i);
      rd(A_STAT, m_stat, "R2 set bit");
      chk_irq("R6 masked off");
      wr(A_ENA, DW'(1) << i);
      rd(A_ENA, m_ena, "R5 readback");
      chk_irq("R6 enabled pending");
      wr(A_CLR, DW'(1) << i);
      rd(A_STAT, m_stat, "R3 clear bit");
      chk_irq("R6 cleared");
      wr(A_ENA, '0);
    end

    // mixed pseudo-random patterns: R2, R3, R5, R6, R8
    for (int k = 0; k < 60; k++) begin
      lfsr = step(lfsr); wr(A_SET, lfsr);
      rd(A_STAT, m_stat, "R2 pattern set");
      chk_irq("R6 after set");
      lfsr = step(lfsr); wr(A_ENA, lfsr & 32'h0F0F_3C3C);
      rd(A_ENA, m_ena, "R5 pattern");
      chk_irq("R6 after enable");
      lfsr = step(lfsr); wr(A_CLR, lfsr);
      rd(A_STAT, m_stat, "R3 pattern clear");
      rd(A_SET, m_stat, "R8 set alias read");
      rd(A_CLR, m_stat, "R8 clear alias read");
      chk_irq("R6 after clear");
    end

    // R4 status write ignored
    wr(A_SET, 32'h0000_00F0);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, m_stat, "R4 status write ignored");
    wr(A_STAT, 32'h0000_0000);
    rd(A_STAT, m_stat, "R4 status zero write ignored");

    // R9 unmapped
    wr(A_ENA, 32'h0000_0F00);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h01, 32'hFFFF_FFFF);
    wr(5'h06, 32'hFFFF_FFFF);
    rd(5'h14, '0, "R9 unmapped read high");
    rd(5'h0D, '0, "R9 unmapped read misaligned");
    rd(A_STAT, m_stat, "R9 status untouched");
    rd(A_ENA, m_ena, "R9 enable untouched");
    chk_irq("R9 irq untouched");

    // R7 hardware events
    wr(A_CLR, 32'hFFFF_FFFF);
    wr(A_ENA, 32'h8000_0001);
    @(negedge clk); hw_evt = 32'h8000_0000;
    @(negedge clk); hw_evt = '0;
    m_stat = m_stat | 32'h8000_0000;
    rd(A_STAT, m_stat, "R7 hw event sets");
    chk_irq("R6 hw event irq");
    // collision: hw sets bit 5 while software clears bits 5 and 6
    wr(A_SET, 32'h0000_0060);
    @(negedge clk);
    hw_evt = 32'h0000_0020; bus_addr = A_CLR; bus_we = 1'b1; bus_wdata = 32'h0000_0060;
    @(negedge clk);
    hw_evt = '0; bus_we = 1'b0;
    m_stat = (m_stat & ~32'h0000_0060) | 32'h0000_0020;
    rd(A_STAT, m_stat, "R7 set beats clear");
    wr(A_CLR, 32'h8000_0000);
    chk_irq("R6 irq drops with status");
    rd(A_STAT, 32'h0000_0020, "R3 bit 5 still pending");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule